// File: doc/BRIEF.md
# Per-hart software interrupt bank

This block holds one 32-bit register word per hart and drives one software interrupt line per hart. Software on any hart writes another hart's word to send it an inter-processor interrupt. The register bus is a simple 32-bit request/response port. Each request is accepted in the cycle it is presented. Its response arrives one cycle later.

A build-time parameter, `SET_ONLY`, picks one of two flavours. With `SET_ONLY = 0`, each word holds a pending flag that software can read, set and clear, and reset clears it. With `SET_ONLY = 1`, software can only raise the interrupt. Reads return zero and reset leaves the flags alone. The interrupt is dropped through a per-hart clear input, which stands in for the receiving core acknowledging it.

Top module: `ipi_bank`

## Requirements
- R1: Hart n's word sits at byte offset 4·n. An access is in range only when its offset is below 4·NUM_HARTS.
- R2: An access is legal only if it meets three conditions. It is in range, its `req_size` is 2 (word), and `req_addr[1:0]` is 0. The other `req_size` codes are 0 (byte), 1 (half) and 3 (double). A request that is not legal pulses `rsp_err` for one cycle alongside its response. It returns zero data and changes no interrupt line.
- R3: In either mode, a legal write with bit 0 set raises that hart's `sw_irq` from the cycle after the request.
- R4: With `SET_ONLY = 0`, a legal write with bit 0 clear lowers that hart's `sw_irq` from the cycle after the request.
- R5: With `SET_ONLY = 1`, a legal write with bit 0 clear leaves `sw_irq` unchanged.
- R6: With `SET_ONLY = 0`, a legal read returns the hart's pending flag in bit 0.
- R7: With `SET_ONLY = 1`, every read returns zero.
- R8: With `SET_ONLY = 0`, a cycle with `rst_n` low clears every pending flag. With `SET_ONLY = 1`, reset leaves the pending flags unchanged.
- R9: With `SET_ONLY = 1`, `hart_clr[n]` high lowers `sw_irq[n]` at the next edge. A legal set write to the same hart in the same cycle wins over the clear. With `SET_ONLY = 0`, `hart_clr` has no effect.
- R10: Every request, legal or not, gives exactly one `rsp_valid` pulse in the next cycle. Idle cycles give none.
- R11: Bits 31:1 of every read are zero. Bits 31:1 of write data are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| req_wdata | input | 32 | Write data, only bit 0 used |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of that response |
| rsp_err | output | 1 | That request was illegal or out of range |
| hart_clr | input | NUM_HARTS | Per-hart interrupt clear (set-only mode) |
| sw_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
A pending flag held in the wrong state shows on `sw_irq` in the very next cycle. In read/write mode it also shows in bit 0 of the following read response. A decode fault can hit the wrong hart or let a bad access through. Either one toggles a neighbouring line or leaves `rsp_err` low in the response cycle. The sweep drives every offset with every size code and compares all lines after each access, so any such fault appears within one access.

// File: rtl/ipi_pkg.sv
// Shared types for the software interrupt bank.
// Assumes a 32-bit register bus with an explicit size code per request.
package ipi_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Decoded request, common to all harts
    typedef struct packed {
        logic legal;     // valid, word-sized, aligned, in range
        logic bad;       // valid but not legal
        logic is_write;  // write request
        logic wbit;      // bit 0 of write data
    } ipi_cmd_t;

endpackage

// File: rtl/ipi_decode.sv
// Address and size decode for the interrupt bank.
// Produces a one-hot hart select and the legality of the current request.
// Assumes ADDR_W >= IDX_W + 2, so every hart's word is addressable.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output ipi_cmd_t             cmd_o,
    output logic [NUM_HARTS-1:0] hit_o
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(4 * NUM_HARTS);

    logic             in_range;
    logic             shape_ok;
    logic [IDX_W-1:0] idx;
    logic             unused_wdata;

    assign unused_wdata = ^req_wdata[31:1];

    // Classify the request: range, size and alignment
    always_comb begin
        in_range       = ({1'b0, req_addr} < LIMIT);
        shape_ok       = (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00);
        idx            = req_addr[IDX_W+1:2];
        cmd_o.legal    = req_valid && in_range && shape_ok;
        cmd_o.bad      = req_valid && !(in_range && shape_ok);
        cmd_o.is_write = req_write;
        cmd_o.wbit     = req_wdata[0];
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
        // One-hot select of the addressed hart for legal requests only
        assign hit_o[h] = cmd_o.legal && (idx == IDX_W'(h));
    end

endmodule

// File: rtl/ipi_cell.sv
// One hart's pending flag. SET_ONLY picks the variant:
//   0: set and clear by bus write, cleared by reset, ext_clr_i unused.
//   1: set by bus write, cleared by ext_clr_i, no reset, set beats clear.
// Assumes set_i and wclr_i are never high together.
module ipi_cell #(
    parameter bit SET_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wclr_i,
    input  logic ext_clr_i,
    output logic pend_o
);
    logic pend_q;

    if (SET_ONLY) begin : g_set_only
        logic unused_in;
        assign unused_in = rst_n ^ wclr_i;

        // Set by write, dropped by the external clear, set has priority
        always_ff @(posedge clk) begin
            if (set_i)          pend_q <= 1'b1;
            else if (ext_clr_i) pend_q <= 1'b0;
        end
    end else begin : g_read_write
        logic unused_in;
        assign unused_in = ext_clr_i;

        // Pending flag under full software control, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)      pend_q <= 1'b0;
            else if (set_i)  pend_q <= 1'b1;
            else if (wclr_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/ipi_resp.sv
// Response stage: registers read data, the valid pulse and the error flag
// one cycle after each request. Read data is zero in set-only mode.
// Assumes hit_i is one-hot or zero.
module ipi_resp
    import ipi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter bit SET_ONLY  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  ipi_cmd_t             cmd_i,
    input  logic [NUM_HARTS-1:0] hit_i,
    input  logic [NUM_HARTS-1:0] pend_i,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err
);
    logic rd_bit;

    // Selected pending flag for a legal read in read/write mode
    always_comb begin
        rd_bit = cmd_i.legal && !cmd_i.is_write && !SET_ONLY && (|(pend_i & hit_i));
    end

    // Register the response for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= {31'b0, rd_bit};
            rsp_err   <= cmd_i.bad;
        end
    end

endmodule

// File: rtl/ipi_bank.sv
// Per-hart software interrupt bank. One word per hart at offset 4*n, with
// bit 0 as the pending flag. SET_ONLY = 0 gives a read/write flag that reset
// clears. SET_ONLY = 1 gives a write-one-to-set flag that reads as zero,
// ignores reset and drops only through hart_clr.
// Assumes a single outstanding request per cycle and ADDR_W >= clog2(4*NUM_HARTS).
module ipi_bank
    import ipi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter bit SET_ONLY  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    input  logic [NUM_HARTS-1:0] hart_clr,
    output logic [NUM_HARTS-1:0] sw_irq
);
    ipi_cmd_t             cmd;
    logic [NUM_HARTS-1:0] hit;
    logic [NUM_HARTS-1:0] pend;

    ipi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .cmd_o     (cmd),
        .hit_o     (hit)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cell
        ipi_cell #(.SET_ONLY(SET_ONLY)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (hit[h] && cmd.is_write && cmd.wbit),
            .wclr_i    (hit[h] && cmd.is_write && !cmd.wbit),
            .ext_clr_i (hart_clr[h]),
            .pend_o    (pend[h])
        );
    end

    ipi_resp #(.NUM_HARTS(NUM_HARTS), .SET_ONLY(SET_ONLY)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cmd_i     (cmd),
        .hit_i     (hit),
        .pend_i    (pend),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    assign sw_irq = pend;

endmodule

// File: rtl/ipi_bank_chk.sv
// Port-level checker for ipi_bank, attached with bind below.
module ipi_bank_chk #(
    parameter int NUM_HARTS = 4,
    parameter bit SET_ONLY  = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic [NUM_HARTS-1:0] hart_clr,
    input logic [NUM_HARTS-1:0] sw_irq
);
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

    a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (SET_ONLY && rsp_valid) |-> (rsp_rdata == 32'd0));

    a_r8_reset_clears: assert property (@(posedge clk)
        (!rst_n && !SET_ONLY) |=> (sw_irq == '0));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        a_r3_rise_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(sw_irq[h])) |-> $past(req_valid && req_write));

        a_r4_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!SET_ONLY && $past(rst_n) && $fell(sw_irq[h])) |-> $past(req_valid && req_write));

        a_r5_fall_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (SET_ONLY && $past(rst_n) && $fell(sw_irq[h])) |-> $past(hart_clr[h]));

        a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (SET_ONLY && hart_clr[h] && !(req_valid && req_write)) |=> !sw_irq[h]);
    end

endmodule

bind ipi_bank ipi_bank_chk #(.NUM_HARTS(NUM_HARTS), .SET_ONLY(SET_ONLY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .hart_clr  (hart_clr),
    .sw_irq    (sw_irq)
);

// File: tb/test_ipi_bank.sv
// Bench: one read/write-mode instance and one set-only instance share a bus.
// Sweeps every offset of a 64-byte window with every size code.
module test_ipi_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_wdata = '0;
    logic [NH-1:0] clr = '0;

    logic          rv_m, rv_s, er_m, er_s;
    logic [31:0]   rd_m, rd_s;
    logic [NH-1:0] irq_m, irq_s;

    logic [NH-1:0] mod_m = '0;
    logic [NH-1:0] mod_s = '0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SET_ONLY(1'b0)) i_ipi_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rv_m), .rsp_rdata(rd_m), .rsp_err(er_m),
        .hart_clr(clr), .sw_irq(irq_m));

    ipi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SET_ONLY(1'b1)) i_ipi_bank_so (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rv_s), .rsp_rdata(rd_s), .rsp_err(er_s),
        .hart_clr(clr), .sw_irq(irq_s));

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One request issued at a falling edge; its results are checked at the next falling edge
    task automatic acc(input bit wr, input int addr, input int sz,
                       input logic [31:0] d, input logic [NH-1:0] c, input string tag);
        bit legal;
        int h;
        logic [31:0] exp_m;
        legal = (sz == 2) && (addr % 4 == 0) && (addr < 4 * NH);
        h = addr / 4;
        exp_m = (!wr && legal) ? {31'b0, mod_m[h]} : 32'd0;
        // model update for the edge ahead
        mod_s = mod_s & ~c;
        if (legal && wr) begin
            mod_m[h] = d[0];
            if (d[0]) mod_s[h] = 1'b1;
        end
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
        req_size = 2'(sz); req_wdata = d; clr = c;
        @(negedge clk);
        req_valid = 1'b0; clr = '0;
        check(rv_m === 1'b1 && rv_s === 1'b1, "R10 response pulse", {30'b0, rv_m, rv_s}, 32'h3);
        check(er_m === !legal && er_s === !legal, "R2 error flag",
              {30'b0, er_m, er_s}, {30'b0, !legal, !legal});
        check(rd_m === exp_m, "R6 R11 R1 read data rw", rd_m, exp_m);
        check(rd_s === 32'd0, "R7 read data set-only", rd_s, 32'd0);
        check(irq_m === mod_m, {tag, " irq rw"}, 32'(irq_m), 32'(mod_m));
        check(irq_s === mod_s, {tag, " irq set-only"}, 32'(irq_s), 32'(mod_s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check(irq_m === '0, "R8 reset clears rw", 32'(irq_m), 0);
        check(rv_m === 1'b0 && rv_s === 1'b0, "R10 no response in reset", {rv_m, rv_s}, 0);
        rst_n = 1'b1;
        // Initialise set-only flags through the clear input
        clr = '1;
        @(negedge clk);
        clr = '0;
        mod_s = '0;
        check(irq_s === '0, "R9 clear input", 32'(irq_s), 0);
        @(negedge clk);
        check(rv_m === 1'b0, "R10 idle no response", 32'(rv_m), 0);

        // Sweep all offsets and size codes: set, read, clear-attempt, read
        for (int a = 0; a < (1 << AW); a++) begin
            for (int s = 0; s < 4; s++) begin
                acc(1'b1, a, s, 32'h0000_0001, '0, "R3 R1 R2 set");
                acc(1'b0, a, s, 32'h0, '0, "R6 read after set");
                acc(1'b1, a, s, 32'hFFFF_FFFE, '0, "R4 R5 R11 write zero");
                acc(1'b0, a, s, 32'h0, '0, "R6 read after zero");
            end
        end

        // Set all harts, then clear input on hart 1 only
        for (int h = 0; h < NH; h++) acc(1'b1, 4*h, 2, 32'h1, '0, "R3 set all");
        acc(1'b0, 0, 2, 32'h0, 4'b0010, "R9 clear hart1");
        // Set write and clear on hart 2 in the same cycle: set wins
        acc(1'b1, 8, 2, 32'h1, 4'b0100, "R9 set beats clear");
        // Machine mode ignores the clear input
        acc(1'b0, 12, 2, 32'h0, 4'b1111, "R9 clear all");
        check(irq_m === 4'b1111, "R9 rw ignores clear", 32'(irq_m), 32'hF);
        acc(1'b1, 12, 2, 32'h0, '0, "R5 set-only ignores zero");

        // Reset retention
        acc(1'b1, 0, 2, 32'h1, '0, "R3 set h0");
        acc(1'b1, 12, 2, 32'h1, '0, "R3 set h3");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mod_m = '0;
        check(irq_m === '0, "R8 rw cleared by reset", 32'(irq_m), 0);
        check(irq_s === 4'b1001, "R8 set-only kept over reset", 32'(irq_s), 32'h9);
        mod_s = 4'b1001;
        acc(1'b0, 12, 2, 32'h0, '0, "R8 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule